// File: doc/BRIEF.md
# Rolling-drum odometer digit counter

This block turns wheel-sensor pulses into the state of a six-digit distance readout whose digits behave like the drums of a mechanical odometer. Each digit is held as a row offset into a glyph strip: ten glyphs of six pixel rows stacked one after another. A digit therefore moves one pixel row per step. When a lower digit sits between "9" and the next "0", the digit above it moves too. The display shows a smooth roll, not a sudden jump.

Distance scaling has no divider. A 16-bit pulse accumulator counts sensor pulses. Inside a window set by the high byte, six fixed low-byte values each produce one row step. One further low-byte value reloads the accumulator, which gives a cycle of irregular length. A separate gate repeats three of every four sensor pulses on a tacho output. A trip reset returns the accumulator and the digits to their start values in one cycle. Glyph lookup, display scanning and saving the state across power cycles are handled elsewhere.

Top module: `odo_drum_counter`

## Requirements
- R1: After `rst`, all six row indices read 1 and `tacho` is 0. The tacho pulse counter restarts, so the next four pulses give tacho, tacho, tacho, none.
- R2: `sensor_n` is active low. Each high-to-low transition counts exactly once, however long the input stays low.
- R3: The accumulator starts at high byte 0, low byte 83, and adds one per counted pulse. When, after that increment, the high byte equals `STEP_HI` (default 17) and the low byte is one of 0x28, 0x50, 0x78, 0xA0, 0xC8 or 0xF0, one row step fires.
- R4: When the incremented accumulator has the high byte equal to `STEP_HI` and the low byte equal to 0xFE, the accumulator reloads to 0/83 and no step fires.
- R5: A step adds one to digit 0, the least significant digit, in `drum_rows[5:0]`. Digit k sits in `drum_rows[6k+5:6k]`. Without a step or trip reset, no index changes.
- R6: Ripple: when an index that has just been incremented becomes 56 or more, the next more significant index is also incremented in the same cycle. The ripple stops at digit 5.
- R7: An index that reaches 61 is stored as 1, so every index stays in the range 1 to 60.
- R8: A pulse counter runs through 0 to 3. The pulse that would bring it to 4 clears it and produces no tacho. Every other pulse raises `tacho`.
- R9: A raised `tacho` stays high while the synchronised sensor input remains low. It falls on the clock edge after that input is seen idle.
- R10: A one-cycle `trip_rst` sets the accumulator to 0/83 and every index to 1 by the next edge. It takes priority over a pulse in the same cycle and leaves the tacho pulse counter unchanged.
- R11: Two synchroniser stages sit in front of the logic. The index and tacho effects of a pulse appear at the third rising edge after `sensor_n` goes low, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| sensor_n | input | 1 | Wheel sensor, low while a pulse is present (asynchronous) |
| trip_rst | input | 1 | One-cycle trip reset of the accumulator and digits |
| tacho | output | 1 | Repeated sensor pulse, three of every four |
| drum_rows | output | 36 | Six 6-bit glyph row indices, digit 0 in the low bits |

## Verification
The bench builds the DUT with the step window at high byte 0 so that complete accumulator cycles fit in a short run. It compares every pulse against a model built from the requirements. Short pulses from reset show where the steps fall and when the first reload happens, which separates the step points from the reload point. A long run drives digit 0 through several full turns until digit 2 moves; this exposes any error in the ripple threshold, the 61-to-1 wrap or the ripple stopping point. Separate patterns cover a held-low pulse, which shows single counting and tacho hold; a probe between edges, which shows latency; and trip and full resets in the middle of a run, which tell apart the state each reset clears.

// File: rtl/odo_pkg.sv
package odo_pkg;

    // glyph strip geometry: ten glyphs of six rows, index 1 is top of "0"
    localparam int IDX_HOME = 1;
    localparam int IDX_ROLL = 56;
    localparam int IDX_WRAP = 61;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } acc_t;

    localparam acc_t ACC_RELOAD = '{hi: 8'h00, lo: 8'd83};
    localparam logic [7:0] LO_WRAP = 8'hFE;

    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_COUNT,
        ACC_STEP,
        ACC_WRAP
    } acc_op_e;

    // classify an already incremented accumulator value
    function automatic acc_op_e acc_classify(input acc_t nxt, input logic [7:0] win_hi);
        if (nxt.hi != win_hi) begin
            return ACC_COUNT;
        end
        case (nxt.lo)
            8'h28, 8'h50, 8'h78, 8'hA0, 8'hC8, 8'hF0: return ACC_STEP;
            LO_WRAP:                                  return ACC_WRAP;
            default:                                  return ACC_COUNT;
        endcase
    endfunction

endpackage

// File: rtl/odo_pulse_sync.sv
module odo_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sensor_n,
    output logic active,
    output logic evt
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    logic              level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], sensor_n};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level  = sh_q[STAGES-1];
    assign active = ~level;
    assign evt    = prev_q & ~level;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);  // R2

endmodule

// File: rtl/odo_acc_scaler.sv
module odo_acc_scaler
    import odo_pkg::*;
#(
    parameter int STEP_HI = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic trip,
    output logic step
);
    localparam logic [7:0] WIN_HI = 8'(STEP_HI);

    acc_t        acc_q;
    acc_t        acc_inc;
    logic [15:0] inc_raw;
    acc_op_e     op;

    assign inc_raw = acc_q + 16'd1;
    assign acc_inc = acc_t'(inc_raw);

    always_comb begin
        op = ACC_HOLD;
        if (evt) begin
            op = acc_classify(acc_inc, WIN_HI);
        end
    end

    assign step = (op == ACC_STEP) && !trip;

    always_ff @(posedge clk) begin
        if (rst || trip) begin
            acc_q <= ACC_RELOAD;
        end else begin
            case (op)
                ACC_HOLD: acc_q <= acc_q;
                ACC_WRAP: acc_q <= ACC_RELOAD;
                default:  acc_q <= acc_inc;
            endcase
        end
    end

    AST_ACC_WINDOW: assert property (@(posedge clk) disable iff (rst)
        acc_q.hi <= WIN_HI);  // R3

    AST_NO_STEP_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (evt && acc_q.hi == WIN_HI && acc_q.lo == 8'hFD) |-> !step);  // R4

    AST_TRIP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        trip |=> (acc_q == ACC_RELOAD));  // R10

endmodule

// File: rtl/odo_drum_chain.sv
module odo_drum_chain
    import odo_pkg::*;
#(
    parameter int NDIG  = 6,
    parameter int ROW_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    input  logic                  trip,
    output logic [NDIG*ROW_W-1:0] rows
);
    localparam logic [ROW_W-1:0] HOME = ROW_W'(IDX_HOME);
    localparam logic [ROW_W-1:0] ROLL = ROW_W'(IDX_ROLL);
    localparam logic [ROW_W-1:0] WRAP = ROW_W'(IDX_WRAP);

    logic [ROW_W-1:0] idx_q [NDIG];
    logic [NDIG-1:0]  inc_en;

    assign inc_en[0] = step;

    for (genvar k = 0; k < NDIG; k++) begin : g_drum
        logic [ROW_W-1:0] sum;
        logic [ROW_W-1:0] nxt;

        assign sum = idx_q[k] + ROW_W'(inc_en[k]);
        assign nxt = (sum == WRAP) ? HOME : sum;

        if (k < NDIG - 1) begin : g_carry
            assign inc_en[k+1] = inc_en[k] && (sum >= ROLL);
        end

        always_ff @(posedge clk) begin
            if (rst || trip) begin
                idx_q[k] <= HOME;
            end else if (inc_en[k]) begin
                idx_q[k] <= nxt;
            end
        end

        assign rows[k*ROW_W +: ROW_W] = idx_q[k];

        AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
            (idx_q[k] >= HOME) && (idx_q[k] < WRAP));  // R7

        AST_IDX_QUIET: assert property (@(posedge clk) disable iff (rst)
            (!step && !trip) |=> $stable(idx_q[k]));  // R5

        if (k > 0) begin : g_ripple_chk
            AST_RIPPLE_MOVES: assert property (@(posedge clk) disable iff (rst)
                (inc_en[k-1] && idx_q[k-1] >= ROLL - 1 && !trip)
                    |=> (idx_q[k] != $past(idx_q[k])));  // R6
        end
    end

endmodule

// File: rtl/odo_tacho_gate.sv
module odo_tacho_gate #(
    parameter int SKIP_EVERY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic active,
    output logic tacho
);
    localparam int CW = (SKIP_EVERY > 2) ? $clog2(SKIP_EVERY) : 1;
    localparam logic [CW-1:0] LAST = CW'(SKIP_EVERY - 1);

    logic [CW-1:0] cnt_q;
    logic          skip;

    assign skip = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tacho <= 1'b0;
        end else begin
            if (evt) begin
                cnt_q <= skip ? '0 : cnt_q + CW'(1);
            end
            if (evt && !skip) begin
                tacho <= 1'b1;
            end else if (!active) begin
                tacho <= 1'b0;
            end
        end
    end

    AST_TACHO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (evt && cnt_q == LAST) |=> !tacho);  // R8

    AST_TACHO_PASS: assert property (@(posedge clk) disable iff (rst)
        (evt && cnt_q != LAST) |=> tacho);  // R8

    AST_TACHO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tacho && active) |=> tacho);  // R9

    AST_TACHO_IDLE_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        evt |-> !tacho);  // R9

endmodule

// File: rtl/odo_drum_counter.sv
module odo_drum_counter #(
    parameter int NDIG        = 6,
    parameter int ROW_W       = 6,
    parameter int STEP_HI     = 17,
    parameter int SKIP_EVERY  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sensor_n,
    input  logic                  trip_rst,
    output logic                  tacho,
    output logic [NDIG*ROW_W-1:0] drum_rows
);
    logic evt;
    logic active;
    logic step;

    odo_pulse_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sensor_n (sensor_n),
        .active   (active),
        .evt      (evt)
    );

    odo_acc_scaler #(
        .STEP_HI (STEP_HI)
    ) u_scaler (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .trip (trip_rst),
        .step (step)
    );

    odo_drum_chain #(
        .NDIG  (NDIG),
        .ROW_W (ROW_W)
    ) u_drums (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .trip (trip_rst),
        .rows (drum_rows)
    );

    odo_tacho_gate #(
        .SKIP_EVERY (SKIP_EVERY)
    ) u_tacho (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .active (active),
        .tacho  (tacho)
    );

endmodule

// File: tb/odo_drum_counter_tb.sv
module odo_drum_counter_tb;

    localparam int NDIG = 6;
    localparam int RW   = 6;
    localparam int WIN  = 0;   // fast step window for the bench

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sensor_n = 1'b1;
    logic                 trip_rst = 1'b0;
    logic                 tacho;
    logic [NDIG*RW-1:0]   drum_rows;

    int n_chk = 0;
    int n_bad = 0;

    // requirement model
    logic [15:0] m_acc;
    int          m_idx [NDIG];
    int          m_tc;
    logic        m_t;

    always #10 clk = ~clk;

    odo_drum_counter #(
        .NDIG    (NDIG),
        .ROW_W   (RW),
        .STEP_HI (WIN)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sensor_n  (sensor_n),
        .trip_rst  (trip_rst),
        .tacho     (tacho),
        .drum_rows (drum_rows)
    );

    task automatic model_home();
        m_acc = 16'd83;
        for (int k = 0; k < NDIG; k++) m_idx[k] = 1;
    endtask

    task automatic model_pulse();
        int k;
        logic [7:0] lo;
        logic stp;
        m_acc = m_acc + 16'd1;
        lo  = m_acc[7:0];
        stp = 1'b0;
        if (m_acc[15:8] == 8'(WIN)) begin
            if (lo == 8'h28 || lo == 8'h50 || lo == 8'h78 ||
                lo == 8'hA0 || lo == 8'hC8 || lo == 8'hF0) stp = 1'b1;
            else if (lo == 8'hFE) m_acc = 16'd83;
        end
        if (stp) begin
            k = 0;
            m_idx[0]++;
            while (k < NDIG - 1 && m_idx[k] >= 56) begin
                k++;
                m_idx[k]++;
            end
            for (int j = 0; j < NDIG; j++) if (m_idx[j] == 61) m_idx[j] = 1;
        end
        m_tc++;
        if (m_tc == 4) begin
            m_tc = 0;
            m_t  = 1'b0;
        end else begin
            m_t = 1'b1;
        end
    endtask

    function automatic logic [NDIG*RW-1:0] model_rows();
        logic [NDIG*RW-1:0] r;
        for (int k = 0; k < NDIG; k++) r[k*RW +: RW] = RW'(m_idx[k]);
        return r;
    endfunction

    task automatic chk_rows(input string tag);
        n_chk++;
        if (drum_rows !== model_rows()) begin
            n_bad++;
            $display("FAIL %s rows got %h exp %h", tag, drum_rows, model_rows());
        end
    endtask

    task automatic chk_bit(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0b exp %0b", tag, got, exp);
        end
    endtask

    // one 3-cycle pulse, called and returning at a falling clock edge
    task automatic pulse(input string tag, input bit check);
        sensor_n = 1'b0;
        @(negedge clk);
        sensor_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_pulse();
        if (check) begin
            chk_rows(tag);
            chk_bit({tag, " tacho"}, tacho, m_t);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_home();
        m_tc = 0;
        m_t  = 1'b0;
        chk_rows("R1 reset rows");
        chk_bit("R1 reset tacho", tacho, 1'b0);
    endtask

    // R3/R5/R11: pulses up to the first step, with the step pulse probed early
    task automatic t_first_step();
        while (m_acc != 16'd119) pulse("R3 pre-step", 1);
        sensor_n = 1'b0;
        @(negedge clk);
        sensor_n = 1'b1;
        @(negedge clk);
        chk_rows("R11 no early change");
        @(negedge clk);
        model_pulse();
        chk_rows("R5 step on digit 0");
        chk_bit("R11 tacho at third edge", tacho, m_t);
    endtask

    // R4: run through the reload point and into the next cycle's steps
    task automatic t_wrap();
        while (m_acc != 16'd253) pulse("R3 steps in window", 1);
        pulse("R4 reload no step", 1);
        n_chk++;
        if (m_acc != 16'd83) begin
            n_bad++;
            $display("FAIL R4 model acc got %0d exp 83", m_acc);
        end
        for (int i = 0; i < 40; i++) pulse("R4 after reload", 1);
    endtask

    // R2/R9: a long low level counts once and holds tacho
    task automatic t_hold_low();
        if (m_tc == 3) pulse("R8 skip pulse", 1);
        sensor_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        model_pulse();
        for (int i = 0; i < 5; i++) begin
            chk_bit("R9 tacho held while low", tacho, 1'b1);
            chk_rows("R2 counted once");
            @(negedge clk);
        end
        sensor_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_bit("R9 tacho still high before idle seen", tacho, 1'b1);
        @(negedge clk);
        chk_bit("R9 tacho falls after idle", tacho, 1'b0);
        pulse("R2 next pulse counted", 1);
    endtask

    // R8: four pulses give tacho on three of them
    task automatic t_tacho_pattern();
        for (int i = 0; i < 8; i++) pulse("R8 tacho pattern", 1);
    endtask

    // R10: trip reset mid-run
    task automatic t_trip();
        for (int i = 0; i < 20; i++) pulse("R10 pre-trip", 1);
        trip_rst = 1'b1;
        @(negedge clk);
        trip_rst = 1'b0;
        model_home();
        chk_rows("R10 trip clears digits");
        for (int i = 0; i < 45; i++) pulse("R10 after trip", 1);
    endtask

    // R6/R7: roll digit 0 through full turns until digit 2 moves
    task automatic t_long_roll();
        for (int i = 0; i < 30000 && m_idx[2] == 1; i++) pulse("R6/R7 drum roll", 1);
        n_chk++;
        if (m_idx[2] == 1 || drum_rows[2*RW +: RW] == RW'(1)) begin
            n_bad++;
            $display("FAIL R6 digit 2 got %0d exp >1", drum_rows[2*RW +: RW]);
        end
    endtask

    // R1: reset in mid-run restarts the tacho counter
    task automatic t_mid_reset();
        pulse("R1 pre-reset", 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_home();
        m_tc = 0;
        m_t  = 1'b0;
        chk_rows("R1 mid reset rows");
        chk_bit("R1 mid reset tacho", tacho, 1'b0);
        for (int i = 0; i < 4; i++) pulse("R1 tacho restart", 1);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_step();
        t_wrap();
        t_hold_low();
        t_tacho_pattern();
        t_trip();
        t_long_roll();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule